// File: doc/BRIEF.md
# Serial Audio Bit and Word Clock Generator

This block derives the timing for a two-direction serial audio port from a fast system clock. Each direction (transmit and receive) owns a programmable divider chain. The chain runs from a source select, through a fixed halving stage, an optional eight-fold prescaler and an 8-bit modulus divider; the modulus output is brought out as a high-frequency clock. A 4-bit divider follows, and its output is the bit clock. A word-length divider then turns bit clocks into a word clock. Every stage advances on single-cycle enables in the system clock domain. Each output pin is a registered toggle with 50% duty, so a pin period is twice the interval between the enables that toggle it.

The source of a chain is either every system clock cycle or a strobe input that marks each cycle of an external crystal, already brought into the system clock domain. A chain can also take its bit clock from an external bit clock pin instead of its own dividers. In synchronous mode the receive side runs on the transmit bit clock and counts words on it using its own word length. Divider ratios are reloaded only when a stage reaches its terminal count, so a configuration change never cuts a period short.

Top module: `sabg_top`

## Requirements
- R1: While reset is high, and in the cycle after it, all six clock outputs are low.
- R2: With the system clock as source and the bit clock generated internally, the bit clock pin period is 4·P·(M+1)·(F+1) system cycles. P is 1 when the prescale select is 0 and 8 when it is 1, M is the 8-bit modulus field (0..255) and F is the 4-bit divider field (0..15).
- R3: Under the same conditions the high-frequency clock pin period is 4·P·(M+1) system cycles, and the bit clock changes only in cycles where the high-frequency clock also changes.
- R4: The word clock toggles once per word, on a rising bit clock edge, so its period is 2·L bit clock periods. Word-size codes: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32 bits.
- R5: Word-size codes 6 to 31 keep the word length that was last loaded.
- R6: With the external crystal as source, each crystal strobe counts as one source cycle. A strobe every 3 cycles with M=0, F=0, P=1 gives a bit clock period of 12 cycles.
- R7: With external bit clock direction selected, the bit clock pin reproduces the period of the external bit clock pin, and the word divider counts its rising edges.
- R8: In synchronous mode the receive bit clock equals the transmit bit clock. The receive word clock changes only on a rising transmit bit clock and uses the receive word-size code.
- R9: In asynchronous mode the receive outputs follow the receive configuration fields alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick_i | input | 1 | One-cycle strobe per external crystal cycle |
| sync_mode_i | input | 1 | 1: receive runs on the transmit bit clock |
| tx_src_ext_i | input | 1 | Transmit source: 0 system clock, 1 crystal strobe |
| tx_pre8_i | input | 1 | Transmit prescale: 0 divide by 1, 1 divide by 8 |
| tx_mod_i | input | 8 | Transmit modulus field, ratio = value+1 |
| tx_hfdiv_i | input | 4 | Transmit bit divider field, ratio = value+1 |
| tx_wlen_i | input | 5 | Transmit word-size code |
| tx_bclk_int_i | input | 1 | Transmit bit clock: 1 internal, 0 external pin |
| tx_bclk_ext_i | input | 1 | Transmit external bit clock pin |
| rx_src_ext_i | input | 1 | Receive source: 0 system clock, 1 crystal strobe |
| rx_pre8_i | input | 1 | Receive prescale select |
| rx_mod_i | input | 8 | Receive modulus field |
| rx_hfdiv_i | input | 4 | Receive bit divider field |
| rx_wlen_i | input | 5 | Receive word-size code |
| rx_bclk_int_i | input | 1 | Receive bit clock: 1 internal, 0 external pin |
| rx_bclk_ext_i | input | 1 | Receive external bit clock pin |
| tx_hfclk_o | output | 1 | Transmit high-frequency clock |
| tx_bclk_o | output | 1 | Transmit bit clock |
| tx_wclk_o | output | 1 | Transmit word clock |
| rx_hfclk_o | output | 1 | Receive high-frequency clock |
| rx_bclk_o | output | 1 | Receive bit clock |
| rx_wclk_o | output | 1 | Receive word clock |

## Verification
Six configurations are measured as periods at the pins. They combine small and full-scale moduli, both prescale settings, the largest 4-bit divider value and every valid word-size code, so a wrong factor in any one stage gives a distinct mismatch in the bit, high-frequency or word period. An invalid code placed after a valid one shows whether the held length is kept, and a valid code after it shows that loading resumes. The crystal strobe and an external bit clock with a period that no internal setting produces separate the source and direction selects from the internal path. Receive periods measured with one configuration on each side in both sync modes show which chain drives the receive pins.

// File: rtl/sabg_pkg.sv
package sabg_pkg;

  localparam int MOD_W      = 8;
  localparam int HF_W       = 4;
  localparam int WL_W       = 5;
  localparam int PRE_RATIO  = 8;
  localparam int FIX_RATIO  = 2;

  typedef struct packed {
    logic            valid;
    logic [WL_W-1:0] len_m1;
  } wlen_dec_t;

  // Word-size code to (length - 1); codes outside 0..5 are flagged invalid.
  function automatic wlen_dec_t wlen_decode(input logic [WL_W-1:0] code);
    wlen_dec_t d;
    d.valid = 1'b1;
    unique case (code)
      5'd0:    d.len_m1 = 5'd7;
      5'd1:    d.len_m1 = 5'd11;
      5'd2:    d.len_m1 = 5'd15;
      5'd3:    d.len_m1 = 5'd19;
      5'd4:    d.len_m1 = 5'd23;
      5'd5:    d.len_m1 = 5'd31;
      default: begin
        d.valid  = 1'b0;
        d.len_m1 = 5'd7;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sabg_div.sv
module sabg_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] ratio_m1_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         at_term;

  assign at_term = (cnt_q == '0);
  assign tick_o  = en_i && at_term;

  // Ratio is sampled only at terminal count, so a period is never cut short.
  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (en_i)
      cnt_q <= at_term ? ratio_m1_i : (cnt_q - W'(1));
  end
endmodule

// File: rtl/sabg_chain.sv
module sabg_chain
  import sabg_pkg::*;
#(
  parameter int MW   = MOD_W,
  parameter int FW   = HF_W,
  parameter int PRE  = PRE_RATIO,
  parameter int FIX  = FIX_RATIO,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xtal_tick_i,
  input  logic          src_ext_i,
  input  logic          pre8_i,
  input  logic [MW-1:0] mod_i,
  input  logic [FW-1:0] hf_i,
  input  logic          bclk_int_i,
  input  logic          bclk_ext_i,
  output logic          hfclk_o,
  output logic          bclk_o,
  output logic          bit_tick_o
);
  localparam int PRE_W = (PRE > 1) ? $clog2(PRE) : 1;
  localparam int FIX_W = (FIX > 1) ? $clog2(FIX) : 1;

  logic src_en, fix_tick, pre_tick, mod_tick, int_edge, ext_edge, edge_tick;
  logic [PRE_W-1:0] pre_ratio;
  logic hf_q, bclk_q;
  logic [SYNC:0] ext_sync_q;

  assign src_en    = src_ext_i ? xtal_tick_i : 1'b1;
  assign pre_ratio = pre8_i ? PRE_W'(PRE - 1) : '0;

  sabg_div #(.W(FIX_W)) u_fix (
    .clk(clk), .rst(rst), .en_i(src_en),
    .ratio_m1_i(FIX_W'(FIX - 1)), .tick_o(fix_tick));

  sabg_div #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en_i(fix_tick),
    .ratio_m1_i(pre_ratio), .tick_o(pre_tick));

  sabg_div #(.W(MW)) u_mod (
    .clk(clk), .rst(rst), .en_i(pre_tick),
    .ratio_m1_i(mod_i), .tick_o(mod_tick));

  sabg_div #(.W(FW)) u_hf (
    .clk(clk), .rst(rst), .en_i(mod_tick),
    .ratio_m1_i(hf_i), .tick_o(int_edge));

  // External pin: synchronizer chain, then detect either edge.
  always_ff @(posedge clk) begin
    if (rst)
      ext_sync_q <= '0;
    else
      ext_sync_q <= {ext_sync_q[SYNC-1:0], bclk_ext_i};
  end
  assign ext_edge  = ext_sync_q[SYNC] ^ ext_sync_q[SYNC-1];
  assign edge_tick = bclk_int_i ? int_edge : ext_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      hf_q   <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      if (mod_tick)  hf_q   <= ~hf_q;
      if (edge_tick) bclk_q <= ~bclk_q;
    end
  end

  assign hfclk_o    = hf_q;
  assign bclk_o     = bclk_q;
  assign bit_tick_o = edge_tick && !bclk_q;
endmodule

// File: rtl/sabg_word.sv
module sabg_word
  import sabg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_tick_i,
  input  logic [WL_W-1:0] code_i,
  output logic            wclk_o
);
  wlen_dec_t       dec;
  logic [WL_W-1:0] held_q, load_m1;
  logic            word_tick, wclk_q;

  assign dec     = wlen_decode(code_i);
  assign load_m1 = dec.valid ? dec.len_m1 : held_q;

  sabg_div #(.W(WL_W)) u_len (
    .clk(clk), .rst(rst), .en_i(bit_tick_i),
    .ratio_m1_i(load_m1), .tick_o(word_tick));

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= WL_W'(7);
      wclk_q <= 1'b0;
    end else if (word_tick) begin
      held_q <= load_m1;
      wclk_q <= ~wclk_q;
    end
  end

  assign wclk_o = wclk_q;
endmodule

// File: rtl/sabg_top.sv
module sabg_top
  import sabg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_tick_i,
  input  logic             sync_mode_i,
  input  logic             tx_src_ext_i,
  input  logic             tx_pre8_i,
  input  logic [MOD_W-1:0] tx_mod_i,
  input  logic [HF_W-1:0]  tx_hfdiv_i,
  input  logic [WL_W-1:0]  tx_wlen_i,
  input  logic             tx_bclk_int_i,
  input  logic             tx_bclk_ext_i,
  input  logic             rx_src_ext_i,
  input  logic             rx_pre8_i,
  input  logic [MOD_W-1:0] rx_mod_i,
  input  logic [HF_W-1:0]  rx_hfdiv_i,
  input  logic [WL_W-1:0]  rx_wlen_i,
  input  logic             rx_bclk_int_i,
  input  logic             rx_bclk_ext_i,
  output logic             tx_hfclk_o,
  output logic             tx_bclk_o,
  output logic             tx_wclk_o,
  output logic             rx_hfclk_o,
  output logic             rx_bclk_o,
  output logic             rx_wclk_o
);
  logic tx_bit_tick, rx_bit_tick, rx_own_bclk, rx_word_bit;

  sabg_chain u_tx_chain (
    .clk(clk), .rst(rst), .xtal_tick_i(xtal_tick_i),
    .src_ext_i(tx_src_ext_i), .pre8_i(tx_pre8_i), .mod_i(tx_mod_i),
    .hf_i(tx_hfdiv_i), .bclk_int_i(tx_bclk_int_i), .bclk_ext_i(tx_bclk_ext_i),
    .hfclk_o(tx_hfclk_o), .bclk_o(tx_bclk_o), .bit_tick_o(tx_bit_tick));

  sabg_chain u_rx_chain (
    .clk(clk), .rst(rst), .xtal_tick_i(xtal_tick_i),
    .src_ext_i(rx_src_ext_i), .pre8_i(rx_pre8_i), .mod_i(rx_mod_i),
    .hf_i(rx_hfdiv_i), .bclk_int_i(rx_bclk_int_i), .bclk_ext_i(rx_bclk_ext_i),
    .hfclk_o(rx_hfclk_o), .bclk_o(rx_own_bclk), .bit_tick_o(rx_bit_tick));

  // Synchronous mode: receive timing follows the transmit bit clock.
  assign rx_word_bit = sync_mode_i ? tx_bit_tick : rx_bit_tick;
  assign rx_bclk_o   = sync_mode_i ? tx_bclk_o   : rx_own_bclk;

  sabg_word u_tx_word (
    .clk(clk), .rst(rst), .bit_tick_i(tx_bit_tick),
    .code_i(tx_wlen_i), .wclk_o(tx_wclk_o));

  sabg_word u_rx_word (
    .clk(clk), .rst(rst), .bit_tick_i(rx_word_bit),
    .code_i(rx_wlen_i), .wclk_o(rx_wclk_o));
endmodule

// File: rtl/sabg_checker.sv
module sabg_checker (
  input logic clk,
  input logic rst,
  input logic sync_mode_i,
  input logic tx_bclk_int_i,
  input logic tx_hfclk_o,
  input logic tx_bclk_o,
  input logic tx_wclk_o,
  input logic rx_hfclk_o,
  input logic rx_bclk_o,
  input logic rx_wclk_o
);
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !(tx_hfclk_o || tx_bclk_o || tx_wclk_o ||
              rx_hfclk_o || rx_bclk_o || rx_wclk_o)); // R1

  AST_HF_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_hfclk_o) |=> $stable(tx_hfclk_o)); // R2

  AST_BCLK_ON_HF: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_bclk_int_i) && !$stable(tx_bclk_o)) |-> !$stable(tx_hfclk_o)); // R3

  AST_TX_WORD_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_wclk_o) |-> $rose(tx_bclk_o)); // R4

  AST_RX_SYNC_WORD: assert property (@(posedge clk) disable iff (rst)
    ($past(sync_mode_i) && sync_mode_i && !$stable(rx_wclk_o)) |-> $rose(tx_bclk_o)); // R8

  AST_RX_WORD_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    ($stable(sync_mode_i) && !$stable(rx_wclk_o)) |-> $rose(rx_bclk_o)); // R9
endmodule

bind sabg_top sabg_checker u_chk (
  .clk(clk), .rst(rst), .sync_mode_i(sync_mode_i), .tx_bclk_int_i(tx_bclk_int_i),
  .tx_hfclk_o(tx_hfclk_o), .tx_bclk_o(tx_bclk_o), .tx_wclk_o(tx_wclk_o),
  .rx_hfclk_o(rx_hfclk_o), .rx_bclk_o(rx_bclk_o), .rx_wclk_o(rx_wclk_o));

// File: tb/sabg_top_tb_top.sv
`timescale 1ns/1ps
module sabg_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xtal_tick = 1'b0, sync_mode = 1'b0;
  logic tx_src_ext = 1'b0, tx_pre8 = 1'b0, tx_bclk_int = 1'b1, tx_bclk_ext = 1'b0;
  logic rx_src_ext = 1'b0, rx_pre8 = 1'b0, rx_bclk_int = 1'b1, rx_bclk_ext = 1'b0;
  logic [7:0] tx_mod = 8'd0, rx_mod = 8'd0;
  logic [3:0] tx_hf = 4'd0, rx_hf = 4'd0;
  logic [4:0] tx_wl = 5'd0, rx_wl = 5'd0;
  logic tx_hfclk, tx_bclk, tx_wclk, rx_hfclk, rx_bclk, rx_wclk;

  always #2.5 clk = ~clk;

  sabg_top dut_i (
    .clk(clk), .rst(rst), .xtal_tick_i(xtal_tick), .sync_mode_i(sync_mode),
    .tx_src_ext_i(tx_src_ext), .tx_pre8_i(tx_pre8), .tx_mod_i(tx_mod),
    .tx_hfdiv_i(tx_hf), .tx_wlen_i(tx_wl), .tx_bclk_int_i(tx_bclk_int),
    .tx_bclk_ext_i(tx_bclk_ext),
    .rx_src_ext_i(rx_src_ext), .rx_pre8_i(rx_pre8), .rx_mod_i(rx_mod),
    .rx_hfdiv_i(rx_hf), .rx_wlen_i(rx_wl), .rx_bclk_int_i(rx_bclk_int),
    .rx_bclk_ext_i(rx_bclk_ext),
    .tx_hfclk_o(tx_hfclk), .tx_bclk_o(tx_bclk), .tx_wclk_o(tx_wclk),
    .rx_hfclk_o(rx_hfclk), .rx_bclk_o(rx_bclk), .rx_wclk_o(rx_wclk));

  // Signal index: 0 tx_hf, 1 tx_b, 2 tx_w, 3 rx_hf, 4 rx_b, 5 rx_w
  int cyc = 0;
  int checks = 0, fails = 0;
  int per [6];
  int last_rise [6];
  int rises [6];
  logic [5:0] prev_s = '0;
  logic [5:0] cur_s;
  assign cur_s = {rx_wclk, rx_bclk, rx_hfclk, tx_wclk, tx_bclk, tx_hfclk};

  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < 6; i++) begin
    per[i] = 0; last_rise[i] = 0; rises[i] = 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < 6; i++)
      if (cur_s[i] && !prev_s[i]) begin
        per[i]       = cyc - last_rise[i];
        last_rise[i] = cyc;
        rises[i]     = rises[i] + 1;
      end
    prev_s = cur_s;
  end

  // Crystal strobe every 3rd cycle; external bit clock pin period 10 cycles.
  int xcnt = 0, ecnt = 0;
  always @(negedge clk) begin
    xcnt      <= (xcnt == 2) ? 0 : xcnt + 1;
    xtal_tick <= (xcnt == 2);
    if (ecnt == 4) begin
      ecnt        <= 0;
      tx_bclk_ext <= ~tx_bclk_ext;
    end else ecnt <= ecnt + 1;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk)
    if (cyc > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion before 190000", cyc);
      finish_run();
    end

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rises(input int idx, input int n);
    int target;
    target = rises[idx] + n;
    while (rises[idx] < target) @(negedge clk);
  endtask

  // {pre8, mod, hf, wlen, exp_bit_period, exp_hf_period, exp_word_period}
  localparam bit [65:0] VECS [0:5] = '{
    {1'b0, 8'd0,   4'd0,  5'd1, 16'd4,    16'd4,    16'd96},
    {1'b0, 8'd2,   4'd1,  5'd2, 16'd24,   16'd12,   16'd768},
    {1'b1, 8'd0,   4'd0,  5'd5, 16'd32,   16'd32,   16'd2048},
    {1'b0, 8'd255, 4'd0,  5'd0, 16'd1024, 16'd1024, 16'd16384},
    {1'b0, 8'd0,   4'd15, 5'd3, 16'd64,   16'd4,    16'd2560},
    {1'b1, 8'd1,   4'd2,  5'd4, 16'd192,  16'd64,   16'd9216}
  };

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs low while reset is held
    check("R1 reset tx_hfclk", int'(tx_hfclk), 0);
    check("R1 reset tx_bclk",  int'(tx_bclk),  0);
    check("R1 reset tx_wclk",  int'(tx_wclk),  0);
    check("R1 reset rx_hfclk", int'(rx_hfclk), 0);
    check("R1 reset rx_bclk",  int'(rx_bclk),  0);
    check("R1 reset rx_wclk",  int'(rx_wclk),  0);
    rst = 1'b0;

    // R2 R3 R4: vector table on the transmit side
    for (int v = 0; v < 6; v++) begin
      {tx_pre8, tx_mod, tx_hf, tx_wl} = VECS[v][65:48];
      wait_rises(2, 3);
      check($sformatf("R2 vec%0d bit period", v), per[1], int'(VECS[v][47:32]));
      check($sformatf("R3 vec%0d hf period", v),  per[0], int'(VECS[v][31:16]));
      check($sformatf("R4 vec%0d word period", v), per[2], int'(VECS[v][15:0]));
    end

    // R5: invalid code holds the previous length (16 bits, Tb=4 -> 128)
    {tx_pre8, tx_mod, tx_hf, tx_wl} = {1'b0, 8'd0, 4'd0, 5'd2};
    wait_rises(2, 3);
    check("R4 code2 word period", per[2], 128);
    tx_wl = 5'd31;
    wait_rises(2, 3);
    check("R5 code31 holds length", per[2], 128);
    tx_wl = 5'd6;
    wait_rises(2, 3);
    check("R5 code6 holds length", per[2], 128);
    tx_wl = 5'd0;
    wait_rises(2, 3);
    check("R5 valid code reloads", per[2], 64);

    // R6: crystal strobe every 3 cycles -> bit period 12, word 8 bits -> 192
    tx_src_ext = 1'b1;
    wait_rises(2, 3);
    check("R6 crystal bit period", per[1], 12);
    check("R6 crystal word period", per[2], 192);
    tx_src_ext = 1'b0;

    // R7: external bit clock pin with period 10 -> word 8 bits -> 160
    tx_bclk_int = 1'b0;
    wait_rises(2, 3);
    check("R7 ext bit period", per[1], 10);
    check("R7 ext word period", per[2], 160);
    tx_bclk_int = 1'b1;

    // R8: sync mode, tx Tb=8; rx own config differs, rx code2 (16 bits)
    tx_hf = 4'd1; tx_wl = 5'd0;
    rx_mod = 8'd5; rx_hf = 4'd3; rx_wl = 5'd2;
    sync_mode = 1'b1;
    wait_rises(5, 3);
    check("R8 sync rx bit period", per[4], 8);
    check("R8 sync rx word period", per[5], 256);
    check("R8 sync tx bit period", per[1], 8);

    // R9: async, rx Tb=4*6*4=96, hf=24, word 2*16*96=3072
    sync_mode = 1'b0;
    wait_rises(5, 3);
    check("R9 async rx bit period", per[4], 96);
    check("R9 async rx hf period", per[3], 24);
    check("R9 async rx word period", per[5], 3072);

    finish_run();
  end
endmodule